// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block holds the speculative mapping from architectural registers to physical register tags in an out-of-order core. Each entry either names the physical tag that will produce the newest value of its architectural register or says that the committed value sits in the architectural register file. Rename writes one entry per cycle. Two read ports return the current mapping for source operands.

For every branch that passes rename, the whole live table is copied into one of a small ring of shadow slots. Slots are handed out in ring order, so a slot number also gives the branch's age. When a branch resolves as correctly predicted, only its own slot is returned. When a branch resolves as mispredicted, its snapshot becomes the live table on the next clock edge. The same edge releases that slot and every younger slot, counting around the ring. A separate clear input returns every entry to the architectural file and releases every slot. This gives the fallback recovery once the machine has drained.

Top module: `ckpt_rat`

## Requirements
- R1: After reset, every entry points at the architectural file (lookup flag 1, tag 0), no slot is held, `br_stall` is 0 and `br_id` is 0.
- R2: A rename writes tag `ren_tag` with flag 0 into entry `ren_arch`. Lookups on the same cycle still show the old entry, and lookups after the next rising edge show the new one.
- R3: Branch slots are granted in ring order 0, 1, …, NUM_CKPT-1, 0. `br_id` shows the slot the next accepted branch takes. The snapshot holds the mapping that includes a rename made in the same cycle as the branch.
- R4: `br_stall` is 1 exactly when the slot at the ring's allocation position is still held, even if other slots are free. A branch request during stall takes no slot and does not move `br_id`.
- R5: A correct resolve releases only its own slot and leaves the live mapping unchanged.
- R6: A mispredict resolve makes the live mapping equal to that branch's snapshot after one rising edge, and `br_id` then equals the mispredicted slot.
- R7: A mispredict releases its slot and every slot allocated after it, counting around the ring. Slots allocated before it stay held.
- R8: A rename or branch request in the same cycle as a mispredict resolve has no effect.
- R9: `drain_clr` returns every entry to the architectural file, releases every slot and sets `br_id` to 0. It overrides rename, branch and resolve inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename write this cycle |
| ren_arch | input | AW | Destination architectural register |
| ren_tag | input | PW | New physical tag for the destination |
| src_a_arch | input | AW | Source A architectural register |
| src_b_arch | input | AW | Source B architectural register |
| src_a_arf | output | 1 | Source A value is in the architectural file |
| src_a_tag | output | PW | Source A physical tag |
| src_b_arf | output | 1 | Source B value is in the architectural file |
| src_b_tag | output | PW | Source B physical tag |
| br_req | input | 1 | A branch is being renamed and needs a slot |
| br_id | output | IW | Slot granted to the branch this cycle |
| br_stall | output | 1 | No slot can be granted this cycle |
| res_valid | input | 1 | A branch resolves this cycle |
| res_miss | input | 1 | The resolving branch was mispredicted |
| res_id | input | IW | Slot of the resolving branch |
| drain_clr | input | 1 | Reset every mapping to the architectural file |

## Verification
The bench builds the block with 8 architectural registers, 32 physical tags and a ring of only 4 slots. With so few slots the pool fills after four branches, so a stall with free holes behind the allocation position is easy to create. The ring also wraps within a few cycles, and a mispredict on a slot near the end of the ring can be made to release younger slots that sit at its start. The small register file lets every entry be read back through the lookup ports after a drain or a restore.

// File: rtl/rat_pkg.sv
package rat_pkg;

    typedef enum logic [1:0] {
        TBL_HOLD    = 2'd0,
        TBL_RENAME  = 2'd1,
        TBL_RESTORE = 2'd2,
        TBL_CLEAR   = 2'd3
    } tbl_op_e;

    // Forward distance from slot from_i to slot to_i on a ring of n slots.
    function automatic int unsigned ring_dist(input int unsigned from_i,
                                              input int unsigned to_i,
                                              input int unsigned n);
        return (to_i >= from_i) ? (to_i - from_i) : (to_i + n - from_i);
    endfunction

endpackage

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
#(
    parameter int NA = 32,
    parameter int EW = 8,
    parameter int AW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tbl_op_e                op,
    input  logic [AW-1:0]          wr_arch,
    input  logic [EW-1:0]          wr_ent,
    input  logic [NA-1:0][EW-1:0]  restore_img,
    input  logic [AW-1:0]          rd_a,
    input  logic [AW-1:0]          rd_b,
    output logic [EW-1:0]          ent_a,
    output logic [EW-1:0]          ent_b,
    output logic [NA-1:0][EW-1:0]  img_d
);
    localparam logic [EW-1:0] ARF_ENT = {1'b1, {(EW-1){1'b0}}};

    typedef struct packed {
        logic [NA-1:0][EW-1:0] tbl;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            TBL_CLEAR: begin
                for (int i = 0; i < NA; i++) st_d.tbl[i] = ARF_ENT;
            end
            TBL_RESTORE: st_d.tbl = restore_img;
            TBL_RENAME:  st_d.tbl[wr_arch] = wr_ent;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) st_q.tbl[i] <= ARF_ENT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_a = st_q.tbl[rd_a];
    assign ent_b = st_q.tbl[rd_b];
    assign img_d = st_d.tbl;

    assert_rename_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == TBL_RENAME |=> st_q.tbl[$past(wr_arch)] == $past(wr_ent));

    assert_restore_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == TBL_RESTORE |=> st_q.tbl == $past(restore_img));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == TBL_HOLD |=> $stable(st_q.tbl));

endmodule

// File: rtl/rat_ckpt_store.sv
module rat_ckpt_store #(
    parameter int N  = 12,
    parameter int IW = 4,
    parameter int NA = 32,
    parameter int EW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_id,
    input  logic [NA-1:0][EW-1:0]  wr_img,
    input  logic [IW-1:0]          rd_id,
    output logic [NA-1:0][EW-1:0]  rd_img
);
    typedef struct packed {
        logic [N-1:0][NA-1:0][EW-1:0] slot;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.slot[wr_id] = wr_img;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_img = st_q.slot[rd_id];

endmodule

// File: rtl/rat_ckpt_pool.sv
module rat_ckpt_pool
    import rat_pkg::*;
#(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic          res_valid,
    input  logic          res_miss,
    input  logic [IW-1:0] res_id,
    input  logic          clear,
    output logic [IW-1:0] alloc_id,
    output logic          stall,
    output logic          alloc_fire
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef struct packed {
        logic [N-1:0]  held;
        logic [IW-1:0] tail;
    } pool_t;

    pool_t st_d, st_q;
    logic miss_now;
    int unsigned span;

    assign miss_now   = res_valid && res_miss && !clear;
    assign stall      = st_q.held[st_q.tail];
    assign alloc_id   = st_q.tail;
    assign alloc_fire = alloc_req && !stall && !miss_now && !clear;

    always_comb begin
        st_d = st_q;
        span = (st_q.tail == res_id) ? 32'(N)
                                     : ring_dist(32'(res_id), 32'(st_q.tail), 32'(N));
        if (clear) begin
            st_d.held = '0;
            st_d.tail = '0;
        end else if (miss_now) begin
            for (int unsigned s = 0; s < 32'(N); s++) begin
                if (ring_dist(32'(res_id), s, 32'(N)) < span) st_d.held[s] = 1'b0;
            end
            st_d.tail = res_id;
        end else begin
            if (res_valid) st_d.held[res_id] = 1'b0;
            if (alloc_fire) begin
                st_d.held[st_q.tail] = 1'b1;
                st_d.tail = (st_q.tail == LAST) ? '0 : st_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_alloc_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> st_q.held[$past(st_q.tail)]);

    assert_full_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.held) == N |-> stall);

    assert_miss_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_now |=> (st_q.tail == $past(res_id)) && !st_q.held[$past(res_id)]);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.held == '0) && (st_q.tail == '0));

    assert_resolve_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !clear) |-> st_q.held[res_id]);

endmodule

// File: rtl/ckpt_rat.sv
module ckpt_rat
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = 32,
    parameter int NUM_PHYS = 128,
    parameter int NUM_CKPT = 12,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int IW = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    input  logic [PW-1:0] ren_tag,
    input  logic [AW-1:0] src_a_arch,
    input  logic [AW-1:0] src_b_arch,
    output logic          src_a_arf,
    output logic [PW-1:0] src_a_tag,
    output logic          src_b_arf,
    output logic [PW-1:0] src_b_tag,
    input  logic          br_req,
    output logic [IW-1:0] br_id,
    output logic          br_stall,
    input  logic          res_valid,
    input  logic          res_miss,
    input  logic [IW-1:0] res_id,
    input  logic          drain_clr
);
    localparam int EW = PW + 1;

    tbl_op_e                       op;
    logic                          fire;
    logic [EW-1:0]                 ent_a, ent_b;
    logic [NUM_ARCH-1:0][EW-1:0]   next_img, snap_img;

    always_comb begin
        if (drain_clr)                   op = TBL_CLEAR;
        else if (res_valid && res_miss)  op = TBL_RESTORE;
        else if (ren_valid)              op = TBL_RENAME;
        else                             op = TBL_HOLD;
    end

    rat_map_table #(.NA(NUM_ARCH), .EW(EW), .AW(AW)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wr_arch     (ren_arch),
        .wr_ent      ({1'b0, ren_tag}),
        .restore_img (snap_img),
        .rd_a        (src_a_arch),
        .rd_b        (src_b_arch),
        .ent_a       (ent_a),
        .ent_b       (ent_b),
        .img_d       (next_img)
    );

    rat_ckpt_pool #(.N(NUM_CKPT), .IW(IW)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (br_req),
        .res_valid  (res_valid),
        .res_miss   (res_miss),
        .res_id     (res_id),
        .clear      (drain_clr),
        .alloc_id   (br_id),
        .stall      (br_stall),
        .alloc_fire (fire)
    );

    rat_ckpt_store #(.N(NUM_CKPT), .IW(IW), .NA(NUM_ARCH), .EW(EW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fire),
        .wr_id  (br_id),
        .wr_img (next_img),
        .rd_id  (res_id),
        .rd_img (snap_img)
    );

    assign src_a_arf = ent_a[EW-1];
    assign src_a_tag = ent_a[PW-1:0];
    assign src_b_arf = ent_b[EW-1];
    assign src_b_tag = ent_b[PW-1:0];

endmodule

// File: tb/tb_ckpt_rat.sv
`timescale 1ns/100ps
module tb_ckpt_rat;
    localparam int NA = 8, NP = 32, NC = 4;
    localparam int AW = 3, PW = 5, IW = 2;
    localparam int ARF_E = 1 << PW;

    logic clk = 0, rst_n = 0;
    logic ren_valid = 0; logic [AW-1:0] ren_arch = 0; logic [PW-1:0] ren_tag = 0;
    logic [AW-1:0] src_a_arch = 0, src_b_arch = 0;
    logic src_a_arf, src_b_arf; logic [PW-1:0] src_a_tag, src_b_tag;
    logic br_req = 0; logic [IW-1:0] br_id; logic br_stall;
    logic res_valid = 0, res_miss = 0; logic [IW-1:0] res_id = 0;
    logic drain_clr = 0;
    int tests = 0, fails = 0; bit done = 0;

    ckpt_rat #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        ren_valid = 0; br_req = 0; res_valid = 0; res_miss = 0; drain_clr = 0;
    endtask

    task automatic look(input int a, output int e);
        src_a_arch = AW'(a); src_b_arch = AW'(NA - 1 - a); #0.1;
        e = {src_a_arf, src_a_tag};
    endtask

    task automatic ren(input int a, input int t);
        ren_valid = 1; ren_arch = AW'(a); ren_tag = PW'(t);
    endtask

    task automatic resolve(input int id, input bit miss);
        res_valid = 1; res_miss = miss; res_id = IW'(id);
    endtask

    task automatic all_arf(input string req);
        int e;
        for (int a = 0; a < NA; a++) begin
            look(a, e); chk(req, e, ARF_E);
            chk(req, {src_b_arf, src_b_tag}, ARF_E);
        end
    endtask

    task automatic t_reset();
        all_arf("R1");
        chk("R1 stall", br_stall, 0);
        chk("R1 id", br_id, 0);
    endtask

    task automatic t_rename();
        int e;
        ren(3, 17);
        look(3, e); chk("R2 same cycle old", e, ARF_E);
        cyc();
        look(3, e); chk("R2 new", e, 17);
        look(4, e); chk("R2 other", e, ARF_E);
    endtask

    task automatic t_snapshot();
        int e;
        drain_clr = 1; cyc();
        ren(5, 9); br_req = 1; chk("R3 id0", br_id, 0); cyc();
        ren(5, 20); cyc();
        chk("R3 id1", br_id, 1);
        look(5, e); chk("R3 live", e, 20);
        resolve(0, 1); cyc();
        look(5, e); chk("R3 snapshot has same-cycle rename", e, 9);
        chk("R6 id rewinds", br_id, 0);
    endtask

    task automatic t_full_stall();
        int e;
        drain_clr = 1; cyc();
        for (int k = 0; k < NC; k++) begin
            chk("R3 ring order", br_id, k); br_req = 1; cyc();
        end
        chk("R4 stall full", br_stall, 1);
        br_req = 1; ren(4, 5); cyc();
        chk("R4 id unmoved", br_id, 0);
        resolve(2, 0); cyc();
        chk("R4 stall with hole", br_stall, 1);
        look(4, e); chk("R5 table unchanged", e, 5);
        resolve(0, 0); cyc();
        chk("R5 own slot freed", br_stall, 0);
        look(4, e); chk("R5 table unchanged", e, 5);
        br_req = 1; cyc();
        chk("R4 next id", br_id, 1);
        chk("R4 slot1 held", br_stall, 1);
    endtask

    task automatic t_wrap_miss();
        int e;
        drain_clr = 1; cyc();
        for (int k = 0; k < NC; k++) begin ren(1, 10 + k); br_req = 1; cyc(); end
        resolve(0, 0); cyc();
        resolve(1, 0); cyc();
        ren(1, 20); br_req = 1; chk("R3 wrap id", br_id, 0); cyc();
        ren(1, 30); cyc();
        resolve(3, 1); ren(2, 7); br_req = 1; cyc();
        look(1, e); chk("R6 restore", e, 13);
        look(2, e); chk("R8 rename dropped", e, ARF_E);
        chk("R8 alloc dropped", br_id, 3);
        chk("R7 stall clear", br_stall, 0);
        for (int k = 0; k < 3; k++) begin
            chk("R7 freed younger", br_stall, 0);
            chk("R7 order", br_id, (3 + k) % NC);
            ren(1, 21 + k); br_req = 1; cyc();
        end
        chk("R7 older kept", br_stall, 1);
        chk("R7 older kept id", br_id, 2);
        resolve(2, 1); cyc();
        look(1, e); chk("R6 restore oldest", e, 12);
        chk("R6 id", br_id, 2);
        for (int k = 0; k < NC; k++) begin
            chk("R7 all freed", br_stall, 0); br_req = 1; cyc();
        end
        chk("R7 refilled", br_stall, 1);
    endtask

    task automatic t_drain();
        ren(6, 3); cyc();
        drain_clr = 1; ren(6, 8); br_req = 1; resolve(1, 1); cyc();
        all_arf("R9");
        chk("R9 stall", br_stall, 0);
        chk("R9 id", br_id, 0);
        for (int k = 0; k < NC; k++) begin
            chk("R9 slots free", br_stall, 0); br_req = 1; cyc();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_rename();
        t_snapshot();
        t_full_stall();
        t_wrap_miss();
        t_drain();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1; tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule